// File: doc/BRIEF.md
# Page-Fault Cause Encoder

This block sits after address translation. Each access arrives as a one-cycle strobe with its linear address, the access kind, the privilege mode and the attribute bits of the page-table entry that mapped it. The block decides in the same cycle whether the access faults. When it does, it registers a 32-bit cause word and a copy of the linear address. Both stay held until the next fault.

The fault pulse, the cause word and the captured address all change on the clock edge that samples the strobe. A separate busy input tells the block that delivery of an earlier fault is still under way. A fault that arrives while busy is high raises a nested-fault flag, and its address still overwrites the held one. Table walking, translation caching and exception dispatch are handled elsewhere.

Top module: `pf_err_reporter`

## Requirements
- R1: A strobe (`acc_valid`=1) faults when any of these holds: the entry is absent (`pte_present`=0); the access is in user mode to a page without user access; the access is a user-mode write to a page that is not writable; the access is a fetch from a no-execute page while `en_xd`=1; or the entry is present with `pte_rsvd_set`=1 while `en_large_page` or `en_ext_addr` is 1. A fault gives `fault_pulse`=1 in the cycle after the strobe. In every other cycle `fault_pulse` is 0. Access kind encoding: 00 read, 01 write, 10 instruction fetch.
- R2: Bit 0 of the cause word is 0 when the entry was absent and 1 when it was present. An absent entry takes priority over every other check.
- R3: Bit 1 is 1 when the faulting access was a write (kind 01) and 0 otherwise.
- R4: Bit 2 is 1 when the faulting access was made in user mode (`acc_user`=1) and 0 in supervisor mode.
- R5: Bit 3 is 1 only when the entry is present, `pte_rsvd_set`=1, and `en_large_page` or `en_ext_addr` is 1. In every other case it is 0.
- R6: Bit 4 is 1 when the faulting access was a fetch (kind 10) and `en_xd`=1. It is 0 whenever `en_xd`=0.
- R7: Bits 31 to 5 of the cause word are always 0.
- R8: Every fault loads `fault_addr` with the full 32-bit address of the faulting access. This includes nested faults.
- R9: `nested_fault` is 1 in the cycle after a faulting strobe that arrived while `deliver_busy`=1. In every other cycle it is 0.
- R10: Without a fault, `err_code` and `fault_addr` keep their values. A strobe that does not fault leaves them unchanged.
- R11: A synchronous active-low reset clears `err_code`, `fault_addr`, `fault_pulse` and `nested_fault` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_addr | input | 32 | Linear address of the access |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor |
| pte_present | input | 1 | Entry present |
| pte_writable | input | 1 | Page writable |
| pte_user | input | 1 | Page accessible from user mode |
| pte_nx | input | 1 | Page marked no-execute |
| pte_rsvd_set | input | 1 | Reserved bits of the entry found nonzero |
| en_large_page | input | 1 | Large-page enable |
| en_ext_addr | input | 1 | Extended-address enable |
| en_xd | input | 1 | Execute-disable enable |
| deliver_busy | input | 1 | Earlier fault still being delivered |
| fault_pulse | output | 1 | One-cycle fault indication |
| nested_fault | output | 1 | Fault arrived during delivery |
| err_code | output | 32 | Registered cause word |
| fault_addr | output | 32 | Registered faulting address |

## Verification
Directed accesses cover three groups. The first is absent entries combined with each kind and mode; these show that absence wins over protection while bits 1, 2 and 4 still follow the access. The second is each single protection cause taken alone, which separates user/supervisor, write and no-execute faults. The third is reserved-bit entries with the enables switched on and off. A long random stream then varies the attributes, the enables and the busy input together. A cycle-level model compares every output on every clock, which exposes stale holds, missing overwrites of the address during nested delivery, and feature bits that leak through while their enable is off.

// File: rtl/pf_pkg.sv
// Package: shared encodings for the page-fault cause encoder.
// Assumes a 2-bit access kind; the value 11 is unused and is treated as a read.
package pf_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_kind_e;

    // Cause-word bit positions; the handler decodes these.
    localparam int unsigned CB_PROT  = 0;
    localparam int unsigned CB_WRITE = 1;
    localparam int unsigned CB_USER  = 2;
    localparam int unsigned CB_RSVD  = 3;
    localparam int unsigned CB_FETCH = 4;
    localparam int unsigned CB_USED  = 5;
endpackage

// File: rtl/pf_cause_eval.sv
// Module: pf_cause_eval
// Decides combinationally whether one access faults and builds its cause word.
// Assumes the attribute bits are valid whenever acc_valid is high.
module pf_cause_eval
    import pf_pkg::*;
#(
    parameter int unsigned CODE_W = 32
) (
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_user,
    input  logic              pte_present,
    input  logic              pte_writable,
    input  logic              pte_user,
    input  logic              pte_nx,
    input  logic              pte_rsvd_set,
    input  logic              en_large_page,
    input  logic              en_ext_addr,
    input  logic              en_xd,
    output logic              fault_hit,
    output logic [CODE_W-1:0] cause
);
    logic is_write, is_fetch, rsvd_chk, prot_viol, rsvd_viol;

    // Classify the access and evaluate each fault source.
    always_comb begin
        is_write  = (acc_kind == ACC_WRITE);
        is_fetch  = (acc_kind == ACC_FETCH);
        rsvd_chk  = en_large_page | en_ext_addr;
        rsvd_viol = pte_present & pte_rsvd_set & rsvd_chk;
        prot_viol = pte_present & (
                        (acc_user & ~pte_user) |
                        (acc_user & is_write & ~pte_writable) |
                        (is_fetch & pte_nx & en_xd));
        fault_hit = acc_valid & (~pte_present | prot_viol | rsvd_viol);
    end

    // Assemble the cause word; the upper bits stay zero.
    always_comb begin
        cause           = '0;
        cause[CB_PROT]  = pte_present;
        cause[CB_WRITE] = is_write;
        cause[CB_USER]  = acc_user;
        cause[CB_RSVD]  = rsvd_viol;
        cause[CB_FETCH] = is_fetch & en_xd;
    end
endmodule

// File: rtl/pf_fault_capture.sv
// Module: pf_fault_capture
// Registers the cause word and faulting address on each fault and holds them
// until the next one. Flags faults that arrive while delivery is busy.
// Assumes the synchronous active-low reset.
module pf_fault_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_hit,
    input  logic [CODE_W-1:0] cause,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              busy,
    input  logic              xd_en,
    input  logic              rsvd_en,
    output logic              pulse,
    output logic              nested,
    output logic [CODE_W-1:0] code_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Capture the cause word and address; every fault overwrites them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            addr_q <= '0;
        end else if (fault_hit) begin
            code_q <= cause;
            addr_q <= addr_in;
        end
    end

    // One-cycle fault and nested-fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            nested <= 1'b0;
        end else begin
            pulse  <= fault_hit;
            nested <= fault_hit & busy;
        end
    end

    AST_HOLD_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> ($stable(code_q) && $stable(addr_q))); // R10
    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (addr_q == $past(addr_in))); // R8
    AST_NEST_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        nested |-> (pulse && $past(busy))); // R9
    AST_FETCH_BIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !$past(xd_en)) |-> !code_q[4]); // R6
    AST_RSVD_BIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !$past(rsvd_en)) |-> !code_q[3]); // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (code_q[CODE_W-1:5] == '0)); // R7
endmodule

// File: rtl/pf_err_reporter.sv
// Module: pf_err_reporter
// Top level: evaluates one translated access per strobe, and on a fault
// registers the cause word, the faulting address and a nested-fault flag.
// Assumes strobes are single-cycle and the inputs are synchronous to clk.
module pf_err_reporter #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_user,
    input  logic              pte_present,
    input  logic              pte_writable,
    input  logic              pte_user,
    input  logic              pte_nx,
    input  logic              pte_rsvd_set,
    input  logic              en_large_page,
    input  logic              en_ext_addr,
    input  logic              en_xd,
    input  logic              deliver_busy,
    output logic              fault_pulse,
    output logic              nested_fault,
    output logic [CODE_W-1:0] err_code,
    output logic [ADDR_W-1:0] fault_addr
);
    logic              hit;
    logic [CODE_W-1:0] cause;

    pf_cause_eval #(.CODE_W(CODE_W)) u_eval (
        .acc_valid     (acc_valid),
        .acc_kind      (acc_kind),
        .acc_user      (acc_user),
        .pte_present   (pte_present),
        .pte_writable  (pte_writable),
        .pte_user      (pte_user),
        .pte_nx        (pte_nx),
        .pte_rsvd_set  (pte_rsvd_set),
        .en_large_page (en_large_page),
        .en_ext_addr   (en_ext_addr),
        .en_xd         (en_xd),
        .fault_hit     (hit),
        .cause         (cause)
    );

    pf_fault_capture #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_hit (hit),
        .cause     (cause),
        .addr_in   (acc_addr),
        .busy      (deliver_busy),
        .xd_en     (en_xd),
        .rsvd_en   (en_large_page | en_ext_addr),
        .pulse     (fault_pulse),
        .nested    (nested_fault),
        .code_q    (err_code),
        .addr_q    (fault_addr)
    );

    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> $past(acc_valid)); // R1
    AST_ABSENT_CLEARS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pulse && !$past(pte_present)) |-> !err_code[0]); // R2
endmodule

// File: tb/pf_err_reporter_tb.sv
// Bench: a behavioural per-clock reference model compared with the design on every cycle.
module pf_err_reporter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_user = 0, pte_present = 0, pte_writable = 0;
    logic        pte_user = 0, pte_nx = 0, pte_rsvd_set = 0;
    logic        en_large_page = 0, en_ext_addr = 0, en_xd = 0, deliver_busy = 0;
    logic [1:0]  acc_kind = 2'b00;
    logic [31:0] acc_addr = '0;
    logic        fault_pulse, nested_fault;
    logic [31:0] err_code, fault_addr;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    // Model state.
    bit          m_pulse = 0, m_nest = 0;
    bit [31:0]   m_code = 0, m_addr = 0;

    always #2 clk = ~clk; // 250 MHz

    pf_err_reporter dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_user(acc_user), .pte_present(pte_present),
        .pte_writable(pte_writable), .pte_user(pte_user), .pte_nx(pte_nx),
        .pte_rsvd_set(pte_rsvd_set), .en_large_page(en_large_page),
        .en_ext_addr(en_ext_addr), .en_xd(en_xd), .deliver_busy(deliver_busy),
        .fault_pulse(fault_pulse), .nested_fault(nested_fault),
        .err_code(err_code), .fault_addr(fault_addr)
    );

    // Reference model: evaluates the requirements at each rising edge.
    always @(posedge clk) begin
        bit wr, fe, usr, flt, rsv;
        if (!rst_n) begin
            m_pulse = 0; m_nest = 0; m_code = 0; m_addr = 0;
        end else begin
            wr  = (acc_kind == 2'd1);
            fe  = (acc_kind == 2'd2);
            usr = acc_user;
            rsv = pte_present && pte_rsvd_set && (en_large_page || en_ext_addr);
            flt = 0;
            if (acc_valid) begin
                if (!pte_present) flt = 1;
                else if (usr && !pte_user) flt = 1;
                else if (usr && wr && !pte_writable) flt = 1;
                else if (fe && pte_nx && en_xd) flt = 1;
                else if (rsv) flt = 1;
            end
            m_pulse = flt;
            m_nest  = flt && deliver_busy;
            if (flt) begin
                m_code = 0;
                if (pte_present) m_code += 1;
                if (wr)          m_code += 2;
                if (usr)         m_code += 4;
                if (rsv)         m_code += 8;
                if (fe && en_xd) m_code += 16;
                m_addr = acc_addr;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model, one field per requirement.
    task automatic compare_all();
        chk("R1 fault_pulse", {31'd0, fault_pulse}, {31'd0, m_pulse});
        chk("R9 nested_fault", {31'd0, nested_fault}, {31'd0, m_nest});
        chk("R2 code bit0", {31'd0, err_code[0]}, {31'd0, m_code[0]});
        chk("R3 code bit1", {31'd0, err_code[1]}, {31'd0, m_code[1]});
        chk("R4 code bit2", {31'd0, err_code[2]}, {31'd0, m_code[2]});
        chk("R5 code bit3", {31'd0, err_code[3]}, {31'd0, m_code[3]});
        chk("R6 code bit4", {31'd0, err_code[4]}, {31'd0, m_code[4]});
        chk("R7 upper bits", {5'd0, err_code[31:5]}, 32'd0);
        chk("R8/R10 fault_addr", fault_addr, m_addr);
    endtask

    task automatic access(input logic [1:0] k, input bit u, input bit p, input bit w,
                          input bit pu, input bit nx, input bit rs, input bit lp,
                          input bit ea, input bit xd, input bit bz, input logic [31:0] a);
        acc_valid = 1; acc_kind = k; acc_user = u; pte_present = p; pte_writable = w;
        pte_user = pu; pte_nx = nx; pte_rsvd_set = rs; en_large_page = lp;
        en_ext_addr = ea; en_xd = xd; deliver_busy = bz; acc_addr = a;
        @(negedge clk);
        acc_valid = 0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            acc_addr = $urandom; // must not disturb held values (R10)
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset pulse", {31'd0, fault_pulse}, 32'd0);
        chk("R11 reset nested", {31'd0, nested_fault}, 32'd0);
        chk("R11 reset code", err_code, 32'd0);
        chk("R11 reset addr", fault_addr, 32'd0);
        rst_n = 1;
        @(negedge clk); compare_all();
        // R2: absent entry wins, other bits follow the access
        access(2'd1, 1, 0, 0, 0, 1, 1, 1, 1, 1, 0, 32'h1000_0004);
        chk("R2 absent code", err_code, 32'h0000_0006);
        access(2'd2, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 32'h2000_0008);
        chk("R6 absent fetch xd", err_code, 32'h0000_0010);
        idle(2);
        // R1: each protection cause alone
        access(2'd0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 32'hA000_0000);
        chk("R1 user-on-sup", err_code, 32'h0000_0005);
        access(2'd1, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 32'hA000_0010);
        chk("R3 user write ro", err_code, 32'h0000_0007);
        access(2'd1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 32'hA000_0020);
        chk("R1 sup write ro no fault", {31'd0, fault_pulse}, 32'd0);
        chk("R10 addr held", fault_addr, 32'hA000_0010);
        access(2'd2, 0, 1, 1, 1, 1, 0, 0, 0, 1, 0, 32'hA000_0030);
        chk("R6 nx fetch", err_code, 32'h0000_0011);
        access(2'd2, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 32'hA000_0040);
        chk("R6 nx ignored xd off", {31'd0, fault_pulse}, 32'd0);
        // R5: reserved bits with enables on and off
        access(2'd0, 0, 1, 1, 1, 0, 1, 1, 0, 0, 0, 32'hB000_0000);
        chk("R5 rsvd large", err_code, 32'h0000_0009);
        access(2'd0, 0, 1, 1, 1, 0, 1, 0, 1, 0, 0, 32'hB000_0004);
        chk("R5 rsvd ext", err_code, 32'h0000_0009);
        access(2'd0, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0, 32'hB000_0008);
        chk("R5 rsvd disabled", {31'd0, fault_pulse}, 32'd0);
        // R8/R9: back-to-back nested faults overwrite the address
        access(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hC000_0001);
        access(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hC000_0002);
        chk("R8 nested addr", fault_addr, 32'hC000_0002);
        chk("R9 nested flag", {31'd0, nested_fault}, 32'd1);
        idle(3);
        // Random stream
        for (int i = 0; i < 3000; i++) begin
            acc_valid = ($urandom_range(0, 3) != 0);
            acc_kind = 2'($urandom_range(0, 2));
            acc_user = 1'($urandom); pte_present = ($urandom_range(0, 4) != 0);
            pte_writable = 1'($urandom); pte_user = 1'($urandom); pte_nx = 1'($urandom);
            pte_rsvd_set = ($urandom_range(0, 3) == 0); en_large_page = 1'($urandom);
            en_ext_addr = 1'($urandom); en_xd = 1'($urandom); deliver_busy = 1'($urandom);
            acc_addr = $urandom;
            @(negedge clk);
            compare_all();
        end
        // R11: synchronous reset mid-run
        rst_n = 0; acc_valid = 0;
        @(negedge clk);
        chk("R11 re-reset code", err_code, 32'd0);
        chk("R11 re-reset addr", fault_addr, 32'd0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule